// File: doc/BRIEF.md
# Single-Bin DFT Impedance Engine

The engine takes a stream of signed ADC samples, drawn at a fixed oversampled rate of 2.048 MSPS, and measures the complex impedance of a device under test at one of three stimulus frequencies: 1 kHz, 10 kHz or 100 kHz. A measurement runs two captures in turn through one shared analog path. The voltage capture comes first and the current capture second. An output select line tells the front end which quantity to route to the ADC. For each capture the engine correlates every sample with a cosine and a sine reference at the test frequency. This yields one DFT bin, with an in-phase part and a quadrature part.

After the second capture the engine forms V·conj(I) and |I|². It then divides both parts of the numerator by |I|² in a pair of sequential restoring dividers, which gives a fixed-point complex impedance. At the same time it sorts the device into one of three classes: inductive, capacitive or resistive. The sort compares the tangent of the impedance phase with a programmable threshold. Software starts a measurement with a pulse and waits for a one-cycle completion pulse. All results hold until the next measurement.

Top module: `dft_impedance_engine`

## Requirements
- R1: The reference phase is a 16-bit accumulator that starts at 0 at the beginning of each capture and advances by a step once per accepted sample. The step is 32 for freq_sel_i=0 (1 kHz), 320 for 1 (10 kHz), 3200 for 2 (100 kHz), and 32 for code 3.
- R2: Let k be phase bits [15:12], S(k) the sine table value for k, and C(k)=S((k+4) mod 16). The table values are 0, 49, 90, 117, 127 for k=0..4. S(k)=S(8-k) for k=5..8, and S(k)=-S(k-8) for k=9..15. Each capture gives re = Σ x·C(k) and im = -Σ x·S(k).
- R3: A start_i pulse while idle latches freq_sel_i, n_samples_i and thr_i. The voltage capture then runs with path_sel_o=0, followed by one gap cycle, followed by the current capture with path_sel_o=1. Each capture accepts exactly n samples, and n_samples_i=0 counts as 1. After reset, busy_o and path_sel_o are 0.
- R4: The engine ignores samples presented while idle or during the gap cycle, and ignores start_i while busy.
- R5: The voltage outputs do not change during the current capture. All result outputs hold while idle, and all are zero after reset.
- R6: z_re_o = ((Vre·Ire + Vim·Iim)·256) / |I|², and z_im_o = ((Vim·Ire − Vre·Iim)·256) / |I|². Both quotients truncate toward zero and are given in two's complement.
- R7: With Nre and Nim the unscaled numerators of R6, dut_class_o is 01 (inductive) when Nim>0 and 256·|Nim| > thr·|Nre|. It is 10 (capacitive) when Nim<0 under the same magnitude test, and 00 (resistive) otherwise.
- R8: done_o is a single-cycle pulse that coincides with busy_o falling, and all results are valid in that cycle.
- R9: The accumulators cannot overflow for up to 4095 full-scale samples per capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a measurement |
| freq_sel_i | input | 2 | Stimulus frequency code |
| n_samples_i | input | CNT_W | Samples per capture |
| thr_i | input | 8 | Phase threshold, tangent in Q0.8 |
| sample_i | input | X_W | Signed ADC sample |
| sample_valid_i | input | 1 | Sample qualifier |
| path_sel_o | output | 1 | 0 routes voltage, 1 routes current |
| busy_o | output | 1 | Measurement in progress |
| done_o | output | 1 | Results valid pulse |
| v_re_o | output | ACC_W | Voltage in-phase sum |
| v_im_o | output | ACC_W | Voltage quadrature sum |
| i_re_o | output | ACC_W | Current in-phase sum |
| i_im_o | output | ACC_W | Current quadrature sum |
| z_re_o | output | Z_W | Impedance real part, Q.8 |
| z_im_o | output | Z_W | Impedance imaginary part, Q.8 |
| dut_class_o | output | 2 | Device class code |

## Verification
The assertions watch the sequencing properties on every cycle: path_sel_o is only high while busy, done_o is a lone pulse that lands as busy falls, the voltage vector is frozen through the current capture, idle results are stable, and the class code is legal and agrees in sign with z_im_o. The numeric content can only be shown by the bench's scenarios. These scenarios cover the correlation sums at every frequency code, the complex quotient and the classification threshold. They also cover the corner cases: the zero-length capture, a full-scale 4095-sample capture, junk samples presented while idle and in the gap cycle, and a start pulse arriving mid-measurement.

// File: rtl/dft_imp_pkg.sv
package dft_imp_pkg;
  localparam int unsigned PH_W = 16;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CAP_V, ST_SWAP, ST_CAP_I, ST_LATCH, ST_MUL, ST_DIV
  } state_e;

  typedef enum logic [1:0] {
    CLS_RES = 2'b00,
    CLS_IND = 2'b01,
    CLS_CAP = 2'b10
  } dut_class_e;

  // phase step for a 2.048 MSPS sample clock
  function automatic logic [PH_W-1:0] phase_step(input logic [1:0] sel);
    case (sel)
      2'd1:    return PH_W'(320);
      2'd2:    return PH_W'(3200);
      default: return PH_W'(32);
    endcase
  endfunction
endpackage

// File: rtl/dft_ref_gen.sv
module dft_ref_gen
  import dft_imp_pkg::*;
#(
  parameter int unsigned REF_W = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clr_i,
  input  logic                    adv_i,
  input  logic [PH_W-1:0]         step_i,
  output logic signed [REF_W-1:0] cos_o,
  output logic signed [REF_W-1:0] sin_o
);
  logic [PH_W-1:0] phase_q;
  logic [3:0]      idx_sin, idx_cos;

  function automatic logic signed [REF_W-1:0] quarter(input logic [2:0] i);
    case (i)
      3'd0:    return REF_W'(0);
      3'd1:    return REF_W'(49);
      3'd2:    return REF_W'(90);
      3'd3:    return REF_W'(117);
      default: return REF_W'(127);
    endcase
  endfunction

  function automatic logic signed [REF_W-1:0] sine16(input logic [3:0] k);
    logic [2:0] off;
    off = {1'b0, k[1:0]};
    case (k[3:2])
      2'd0:    return quarter(off);
      2'd1:    return quarter(3'd4 - off);
      2'd2:    return -quarter(off);
      default: return -quarter(3'd4 - off);
    endcase
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    phase_q <= '0;
    else if (clr_i) phase_q <= '0;
    else if (adv_i) phase_q <= phase_q + step_i;
  end

  assign idx_sin = phase_q[PH_W-1 -: 4];
  assign idx_cos = idx_sin + 4'd4;
  assign sin_o   = sine16(idx_sin);
  assign cos_o   = sine16(idx_cos);
endmodule

// File: rtl/dft_correlator.sv
module dft_correlator #(
  parameter int unsigned X_W   = 12,
  parameter int unsigned REF_W = 8,
  parameter int unsigned ACC_W = 31
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clr_i,
  input  logic                    en_i,
  input  logic signed [X_W-1:0]   x_i,
  input  logic signed [REF_W-1:0] cos_i,
  input  logic signed [REF_W-1:0] sin_i,
  output logic signed [ACC_W-1:0] re_o,
  output logic signed [ACC_W-1:0] im_o
);
  localparam int unsigned P_W = X_W + REF_W;

  logic signed [REF_W-1:0] ref_w [2];
  logic signed [ACC_W-1:0] acc_q [2];

  assign ref_w[0] = cos_i;
  assign ref_w[1] = sin_i;

  for (genvar c = 0; c < 2; c++) begin : g_ch
    logic signed [P_W-1:0] prod;
    assign prod = x_i * ref_w[c];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     acc_q[c] <= '0;
      else if (clr_i)  acc_q[c] <= '0;
      else if (en_i) begin
        // quadrature term carries the negative DFT kernel sign
        if (c == 0) acc_q[c] <= acc_q[c] + ACC_W'(prod);
        else        acc_q[c] <= acc_q[c] - ACC_W'(prod);
      end
    end
  end

  assign re_o = acc_q[0];
  assign im_o = acc_q[1];
endmodule

// File: rtl/dft_div.sv
module dft_div #(
  parameter int unsigned W     = 72,
  parameter int unsigned DEN_W = 63
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic signed [W-1:0] num_i,
  input  logic [DEN_W-1:0]    den_i,
  output logic signed [W-1:0] quo_o,
  output logic                done_o
);
  localparam int unsigned CNT_W = $clog2(W + 1);

  logic [W-1:0]       q_q;
  logic [DEN_W-1:0]   rem_q, d_q;
  logic [DEN_W:0]     rem_sh;
  logic               ge, neg_q, done_q;
  logic [CNT_W-1:0]   cnt_q;

  assign rem_sh = {rem_q, q_q[W-1]};
  assign ge     = rem_sh >= {1'b0, d_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q <= '0; rem_q <= '0; d_q <= '0; neg_q <= 1'b0;
      cnt_q <= '0; done_q <= 1'b0;
    end else if (start_i) begin
      q_q    <= num_i[W-1] ? W'(-num_i) : W'(num_i);
      neg_q  <= num_i[W-1];
      d_q    <= den_i;
      rem_q  <= '0;
      cnt_q  <= CNT_W'(W);
      done_q <= 1'b0;
    end else if (cnt_q != '0) begin
      rem_q  <= DEN_W'(ge ? rem_sh - {1'b0, d_q} : rem_sh);
      q_q    <= {q_q[W-2:0], ge};
      cnt_q  <= cnt_q - 1'b1;
      done_q <= (cnt_q == CNT_W'(1));
    end else begin
      done_q <= 1'b0;
    end
  end

  assign quo_o  = neg_q ? -$signed(q_q) : $signed(q_q);
  assign done_o = done_q;
endmodule

// File: rtl/dft_impedance_engine.sv
module dft_impedance_engine
  import dft_imp_pkg::*;
#(
  parameter int unsigned X_W    = 12,
  parameter int unsigned REF_W  = 8,
  parameter int unsigned CNT_W  = 12,
  parameter int unsigned FRAC_W = 8,
  localparam int unsigned ACC_W  = X_W + REF_W - 1 + CNT_W,
  localparam int unsigned PROD_W = 2 * ACC_W,
  localparam int unsigned Z_W    = PROD_W + 2 + FRAC_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic [1:0]              freq_sel_i,
  input  logic [CNT_W-1:0]        n_samples_i,
  input  logic [7:0]              thr_i,
  input  logic signed [X_W-1:0]   sample_i,
  input  logic                    sample_valid_i,
  output logic                    path_sel_o,
  output logic                    busy_o,
  output logic                    done_o,
  output logic signed [ACC_W-1:0] v_re_o,
  output logic signed [ACC_W-1:0] v_im_o,
  output logic signed [ACC_W-1:0] i_re_o,
  output logic signed [ACC_W-1:0] i_im_o,
  output logic signed [Z_W-1:0]   z_re_o,
  output logic signed [Z_W-1:0]   z_im_o,
  output logic [1:0]              dut_class_o
);
  localparam int unsigned DEN_W = PROD_W + 1;
  localparam int unsigned CMP_W = PROD_W + 1 + 8;

  state_e           state_q;
  logic [PH_W-1:0]  step_q;
  logic [CNT_W-1:0] n_q, cnt_q;
  logic [7:0]       thr_q;
  logic             corr_clr, corr_en, div_start;
  logic signed [REF_W-1:0] cos_w, sin_w;
  logic signed [ACC_W-1:0] corr_re, corr_im;
  logic signed [ACC_W-1:0] v_re_q, v_im_q, i_re_q, i_im_q;
  logic signed [Z_W-1:0]   z_re_q, z_im_q;
  dut_class_e       cls_q, cls_pend_q, cls_c;
  logic             done_q;

  assign corr_clr  = (state_q == ST_IDLE && start_i) || state_q == ST_SWAP;
  assign corr_en   = sample_valid_i && (state_q == ST_CAP_V || state_q == ST_CAP_I);
  assign div_start = state_q == ST_MUL;

  dft_ref_gen #(.REF_W(REF_W)) u_ref (
    .clk_i, .rst_ni, .clr_i(corr_clr), .adv_i(corr_en), .step_i(step_q),
    .cos_o(cos_w), .sin_o(sin_w)
  );

  dft_correlator #(.X_W(X_W), .REF_W(REF_W), .ACC_W(ACC_W)) u_corr (
    .clk_i, .rst_ni, .clr_i(corr_clr), .en_i(corr_en), .x_i(sample_i),
    .cos_i(cos_w), .sin_i(sin_w), .re_o(corr_re), .im_o(corr_im)
  );

  // V * conj(I) and |I|^2
  logic signed [PROD_W:0] vr_x, vi_x, ir_x, ii_x, nre_c, nim_c, den_c;
  assign vr_x  = v_re_q;
  assign vi_x  = v_im_q;
  assign ir_x  = i_re_q;
  assign ii_x  = i_im_q;
  assign nre_c = vr_x * ir_x + vi_x * ii_x;
  assign nim_c = vi_x * ir_x - vr_x * ii_x;
  assign den_c = ir_x * ir_x + ii_x * ii_x;

  // phase classifier: compare tan(phase) against thr/256
  logic [PROD_W:0] re_mag, im_mag;
  logic [CMP_W-1:0] lhs_c, rhs_c;
  assign re_mag = nre_c[PROD_W] ? -nre_c : nre_c;
  assign im_mag = nim_c[PROD_W] ? -nim_c : nim_c;
  assign lhs_c  = CMP_W'(im_mag) << 8;
  assign rhs_c  = CMP_W'(re_mag) * CMP_W'(thr_q);

  always_comb begin
    cls_c = CLS_RES;
    if (lhs_c > rhs_c) cls_c = nim_c[PROD_W] ? CLS_CAP : CLS_IND;
  end

  logic signed [Z_W-1:0] num_w [2];
  logic signed [Z_W-1:0] quo_w [2];
  logic [1:0]            div_done;
  assign num_w[0] = Z_W'(nre_c) <<< FRAC_W;
  assign num_w[1] = Z_W'(nim_c) <<< FRAC_W;

  for (genvar d = 0; d < 2; d++) begin : g_div
    dft_div #(.W(Z_W), .DEN_W(DEN_W)) u_div (
      .clk_i, .rst_ni, .start_i(div_start), .num_i(num_w[d]),
      .den_i(DEN_W'(den_c)), .quo_o(quo_w[d]), .done_o(div_done[d])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      step_q  <= '0; n_q <= '0; cnt_q <= '0; thr_q <= '0;
      v_re_q  <= '0; v_im_q <= '0; i_re_q <= '0; i_im_q <= '0;
      z_re_q  <= '0; z_im_q <= '0;
      cls_q   <= CLS_RES; cls_pend_q <= CLS_RES;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (start_i) begin
          step_q  <= phase_step(freq_sel_i);
          n_q     <= (n_samples_i == '0) ? CNT_W'(1) : n_samples_i;
          thr_q   <= thr_i;
          cnt_q   <= '0;
          state_q <= ST_CAP_V;
        end
        ST_CAP_V, ST_CAP_I: if (sample_valid_i) begin
          if (cnt_q == n_q - CNT_W'(1)) begin
            cnt_q   <= '0;
            state_q <= (state_q == ST_CAP_V) ? ST_SWAP : ST_LATCH;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        ST_SWAP: begin
          v_re_q  <= corr_re;
          v_im_q  <= corr_im;
          state_q <= ST_CAP_I;
        end
        ST_LATCH: begin
          i_re_q  <= corr_re;
          i_im_q  <= corr_im;
          state_q <= ST_MUL;
        end
        ST_MUL: begin
          cls_pend_q <= cls_c;
          state_q    <= ST_DIV;
        end
        ST_DIV: if (&div_done) begin
          z_re_q  <= quo_w[0];
          z_im_q  <= quo_w[1];
          cls_q   <= cls_pend_q;
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign path_sel_o  = state_q == ST_CAP_I;
  assign busy_o      = state_q != ST_IDLE;
  assign done_o      = done_q;
  assign v_re_o      = v_re_q;
  assign v_im_o      = v_im_q;
  assign i_re_o      = i_re_q;
  assign i_im_o      = i_im_q;
  assign z_re_o      = z_re_q;
  assign z_im_o      = z_im_q;
  assign dut_class_o = cls_q;
endmodule

// File: rtl/dft_impedance_engine_chk.sv
module dft_impedance_engine_chk #(
  parameter int unsigned ACC_W = 31,
  parameter int unsigned Z_W   = 72
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    start_i,
  input logic                    path_sel_o,
  input logic                    busy_o,
  input logic                    done_o,
  input logic signed [ACC_W-1:0] v_re_o,
  input logic signed [ACC_W-1:0] v_im_o,
  input logic signed [Z_W-1:0]   z_re_o,
  input logic signed [Z_W-1:0]   z_im_o,
  input logic [1:0]              dut_class_o
);
  p_path_busy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    path_sel_o |-> busy_o);

  p_hold_v_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    path_sel_o |=> ($stable(v_re_o) && $stable(v_im_o)));

  p_hold_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> ($stable(z_re_o) && $stable(z_im_o) &&
                               $stable(v_re_o) && $stable(dut_class_o)));

  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  p_class_code_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(dut_class_o));

  p_class_ind_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && dut_class_o == 2'b01) |-> !z_im_o[Z_W-1]);

  p_class_cap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && dut_class_o == 2'b10) |-> (z_im_o[Z_W-1] || z_im_o == '0));
endmodule

bind dft_impedance_engine dft_impedance_engine_chk #(.ACC_W(ACC_W), .Z_W(Z_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .path_sel_o(path_sel_o),
  .busy_o(busy_o), .done_o(done_o), .v_re_o(v_re_o), .v_im_o(v_im_o),
  .z_re_o(z_re_o), .z_im_o(z_im_o), .dut_class_o(dut_class_o)
);

// File: tb/dft_impedance_engine_bench.sv
module dft_impedance_engine_bench;
  localparam int X_W = 12, CNT_W = 12, ACC_W = 31, Z_W = 72;

  logic clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0, sample_valid_i = 1'b0;
  logic [1:0] freq_sel_i = '0;
  logic [CNT_W-1:0] n_samples_i = '0;
  logic [7:0] thr_i = '0;
  logic signed [X_W-1:0] sample_i = '0;
  logic path_sel_o, busy_o, done_o;
  logic signed [ACC_W-1:0] v_re_o, v_im_o, i_re_o, i_im_o;
  logic signed [Z_W-1:0] z_re_o, z_im_o;
  logic [1:0] dut_class_o;

  int errors = 0, checks = 0;

  always #4 clk_i = ~clk_i;

  dft_impedance_engine u_dft_impedance_engine (.*);

  typedef struct packed {
    logic [1:0] freq; logic [11:0] n; logic [7:0] thr;
    logic signed [7:0] va, vb, ia, ib;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{2'd2, 12'd512,  8'd64,  8'sd8,  8'sd0,  8'sd8,  8'sd0},
    '{2'd2, 12'd512,  8'd64,  8'sd0,  8'sd8,  8'sd8,  8'sd0},
    '{2'd1, 12'd1024, 8'd64,  8'sd0, -8'sd8,  8'sd8,  8'sd0},
    '{2'd0, 12'd2048, 8'd64,  8'sd6, -8'sd6,  8'sd4,  8'sd2},
    '{2'd3, 12'd2048, 8'd255, 8'sd5, -8'sd3,  8'sd2,  8'sd7},
    '{2'd2, 12'd0,    8'd10,  8'sd7,  8'sd3,  8'sd5, -8'sd2},
    '{2'd1, 12'd100,  8'd128, 8'sd3,  8'sd9, -8'sd8,  8'sd4}
  };

  function automatic int qv(int i);
    case (i) 0: return 0; 1: return 49; 2: return 90; 3: return 117; default: return 127; endcase
  endfunction
  function automatic int s16(int k);
    if (k <= 4) return qv(k);
    if (k <= 8) return qv(8 - k);
    if (k <= 12) return -qv(k - 8);
    return -qv(16 - k);
  endfunction
  function automatic int c16(int k); return s16((k + 4) % 16); endfunction
  function automatic int step_of(int f);
    return (f == 1) ? 320 : (f == 2) ? 3200 : 32;
  endfunction
  function automatic int kidx(int f, int n); return ((n * step_of(f)) % 65536) / 4096; endfunction
  function automatic int samp(int full, int a, int b, int k);
    if (full != 0) return (c16(k) >= 0) ? 2047 : -2048;
    return a * c16(k) + b * s16(k);
  endfunction

  task automatic chk(input bit ok, input string req, input logic signed [127:0] act,
                     input logic signed [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle_junk(int cyc);
    for (int j = 0; j < cyc; j++) begin
      @(negedge clk_i); sample_valid_i = 1'b1; sample_i = 12'sh5A5;
    end
    @(negedge clk_i); sample_valid_i = 1'b0;
  endtask

  // one full measurement; vfull selects full-scale voltage, bstart pulses start mid-capture
  task automatic run(input vec_t v, input int vfull, input int bstart);
    int n, k, xs, dcnt, cyc;
    longint vr, vi, ir, ii;
    logic signed [127:0] nre, nim, den, ere, eim, mre, mim;
    logic [1:0] ecls;
    n = (v.n == 0) ? 1 : int'(v.n);
    vr = 0; vi = 0; ir = 0; ii = 0;
    for (int s = 0; s < n; s++) begin
      k = kidx(v.freq, s);
      xs = samp(vfull, v.va, v.vb, k);
      vr += longint'(xs) * c16(k); vi -= longint'(xs) * s16(k);
      xs = samp(0, v.ia, v.ib, k);
      ir += longint'(xs) * c16(k); ii -= longint'(xs) * s16(k);
    end
    idle_junk(3);
    freq_sel_i = v.freq; n_samples_i = v.n; thr_i = v.thr; start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    freq_sel_i = 2'd2; n_samples_i = 12'd7; thr_i = 8'd0;
    for (int s = 0; s < n; s++) begin
      sample_valid_i = 1'b1; sample_i = X_W'(samp(vfull, v.va, v.vb, kidx(v.freq, s)));
      @(negedge clk_i);
    end
    chk(path_sel_o == 1'b0 && busy_o, "R3 gap after voltage", path_sel_o, 0);
    cyc = 0;
    while (!path_sel_o && cyc < 10) begin
      sample_valid_i = 1'b1; sample_i = 12'sh7FF; // gap junk, R4
      @(negedge clk_i); cyc++;
    end
    for (int s = 0; s < n; s++) begin
      sample_valid_i = 1'b1; sample_i = X_W'(samp(0, v.ia, v.ib, kidx(v.freq, s)));
      start_i = (bstart != 0 && s == 2);
      @(negedge clk_i);
    end
    start_i = 1'b0; sample_valid_i = 1'b0;
    chk(path_sel_o == 1'b0, "R3 current capture length", path_sel_o, 0);
    dcnt = 0;
    while (!done_o && dcnt < 300) begin @(negedge clk_i); dcnt++; end
    chk(done_o && !busy_o, "R8 done with busy low", done_o, 1);
    nre = 128'(vr) * 128'(ir) + 128'(vi) * 128'(ii);
    nim = 128'(vi) * 128'(ir) - 128'(vr) * 128'(ii);
    den = 128'(ir) * 128'(ir) + 128'(ii) * 128'(ii);
    ere = (nre <<< 8) / den;
    eim = (nim <<< 8) / den;
    mre = (nre < 0) ? -nre : nre;
    mim = (nim < 0) ? -nim : nim;
    ecls = 2'b00;
    if (mim * 256 > mre * v.thr) ecls = (nim > 0) ? 2'b01 : 2'b10;
    chk(v_re_o == ACC_W'(vr), "R1 R2 R9 v_re", v_re_o, vr);
    chk(v_im_o == ACC_W'(vi), "R2 R4 v_im", v_im_o, vi);
    chk(i_re_o == ACC_W'(ir), "R2 i_re", i_re_o, ir);
    chk(i_im_o == ACC_W'(ii), "R2 i_im", i_im_o, ii);
    chk(128'(z_re_o) == ere, "R6 z_re", z_re_o, ere);
    chk(128'(z_im_o) == eim, "R6 z_im", z_im_o, eim);
    chk(dut_class_o == ecls, "R7 class", dut_class_o, ecls);
    @(negedge clk_i);
    chk(!done_o && !busy_o, "R8 single pulse, R4 start ignored", done_o, 0);
    idle_junk(4);
    chk(128'(z_re_o) == ere && v_re_o == ACC_W'(vr), "R5 hold while idle", z_re_o, ere);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++; checks++;
    $display("FAIL R8 watchdog actual=hang expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(!busy_o && !path_sel_o && !done_o, "R3 reset idle", busy_o, 0);
    chk(z_re_o == '0 && v_re_o == '0 && i_im_o == '0 && dut_class_o == 2'b00,
        "R5 reset zero", z_re_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    for (int i = 0; i < NV; i++) run(VECS[i], 0, 0);
    // R9: full-scale voltage, 4095 samples at 100 kHz
    run('{2'd2, 12'd4095, 8'd64, 8'sd0, 8'sd0, 8'sd8, 8'sd3}, 1, 0);
    // R4: start pulse during current capture is ignored
    run('{2'd2, 12'd256, 8'd32, 8'sd4, 8'sd5, 8'sd6, -8'sd1}, 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule